// File: doc/BRIEF.md
# SIM Card Supply and Bit-Rate Controller

This block powers up a subscriber card, watches for its answer to reset, and produces the bit-rate tick that the serial layer above it uses. The card is always powered first at the 1.8 V class. If no answer arrives within a set number of card clocks, the block takes the card down in order and tries again at the 3 V class. If the 3 V attempt also gets no answer, it flags a card error and keeps the card unpowered until the card is taken out.

All sequencing runs on card-clock enables (`cclk_en`), which are single system-clock pulses, one for each card clock period. Activation raises the supply, then starts the card clock, then releases card reset, with one card clock between each step. Deactivation undoes these steps in the reverse order. The card slot sits under the battery, so a missing battery drops everything at once, without the orderly sequence. A two-bit code selects the bit-tick divisor. The framing and protocol layers above the answer to reset live elsewhere.

Top module: `sim_pwr_ctrl`

## Requirements
- R1: After reset all card-facing outputs are low: supply, clock gate, card reset release (`card_rst_n`), bit tick, card error and class select. `sel_3v0` = 0 means the 1.8 V class.
- R2: With battery and card present and no error latched, the supply rises on a card-clock enable. The clock gate rises on the next enable. `card_rst_n` rises on the enable after that. The first attempt uses `sel_3v0` = 0.
- R3: An `atr_seen` pulse while waiting after reset release keeps the card active. No timeout follows, however many card clocks then pass.
- R4: With no `atr_seen`, the ATR_LIMIT-th enable after reset release drops `card_rst_n`. The next enable stops the clock and the enable after that removes the supply.
- R5: After a failed 1.8 V attempt, `sel_3v0` becomes 1 as the supply goes off. Activation then repeats at the 3 V class without the card being reinserted.
- R6: After a failed 3 V attempt, `card_err` goes to 1 and `sel_3v0` returns to 0. The supply stays off while the card remains present. Removing the card clears `card_err`.
- R7: When `batt_present` is low at a clock edge, all card outputs are off after that edge, whatever the state. `card_err` is cleared and the class returns to 1.8 V.
- R8: When `card_present` goes low while the card is powered, the block runs the ordered deactivation of R4 with no error and no class change.
- R9: While the card clock is gated on, `bit_tick` pulses for one system clock every N enables. `rate_code` 0 gives N = 372, 1 gives N = 64, 2 gives N = 32 and 3 gives N = 16. There is no tick while the clock is off.
- R10: Sequencing, timeout counting and the bit divider advance only on cycles with `cclk_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| batt_present | input | 1 | Battery in place; low forces an immediate power-down |
| card_present | input | 1 | Card detected in the slot |
| atr_seen | input | 1 | One-cycle strobe: answer to reset received |
| cclk_en | input | 1 | One-cycle enable per card clock period |
| rate_code | input | 2 | Bit-tick divisor select |
| sup_en | output | 1 | Card supply enable |
| sel_3v0 | output | 1 | Supply class: 0 = 1.8 V, 1 = 3 V |
| card_rst_n | output | 1 | Card reset, low = held in reset |
| cclk_gate | output | 1 | Card clock running |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| card_err | output | 1 | Both supply classes failed |

## Verification
The bench runs the full two-class fallback. A design that raised 3 V at once, retried forever, or changed class while powered would show the wrong `sel_3v0` or `sup_en` on the cycle the reference model predicts. It measures the timeout window with a sparse enable pattern, which exposes an off-by-one in the limit or a counter that runs on every system clock. It removes the battery in the middle of a session, which catches a design that steps through the orderly teardown or keeps a stale error or class. It times the gaps between bit ticks for all four codes, which exposes swapped codes or a divider that wraps one count late.

// File: rtl/sim_pwr_pkg.sv
package sim_pwr_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_VCC  = 3'd1,
    ST_CLK  = 3'd2,
    ST_WAIT = 3'd3,
    ST_RUN  = 3'd4,
    ST_DRST = 3'd5,
    ST_DCLK = 3'd6
  } seq_t;

  typedef struct packed {
    logic vcc;
    logic clk;
    logic rls;
  } pins_t;

  // Card pin levels owned by each sequence step.
  function automatic pins_t pins_of(seq_t s);
    pins_t p;
    p = '0;
    case (s)
      ST_VCC:  p = '{vcc: 1'b1, clk: 1'b0, rls: 1'b0};
      ST_CLK:  p = '{vcc: 1'b1, clk: 1'b1, rls: 1'b0};
      ST_WAIT: p = '{vcc: 1'b1, clk: 1'b1, rls: 1'b1};
      ST_RUN:  p = '{vcc: 1'b1, clk: 1'b1, rls: 1'b1};
      ST_DRST: p = '{vcc: 1'b1, clk: 1'b1, rls: 1'b0};
      ST_DCLK: p = '{vcc: 1'b1, clk: 1'b0, rls: 1'b0};
      default: p = '0;
    endcase
    return p;
  endfunction

  // Divisor chosen by the two-bit rate code.
  function automatic int unsigned pick_div(logic [1:0] code, int unsigned d0,
                                           int unsigned d1, int unsigned d2,
                                           int unsigned d3);
    case (code)
      2'd0:    return d0;
      2'd1:    return d1;
      2'd2:    return d2;
      default: return d3;
    endcase
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sim_atr_timer.sv
module sim_atr_timer #(
  parameter int unsigned ATR_LIMIT = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic tick,
  output logic expire
);
  localparam int unsigned CW = $clog2(ATR_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(ATR_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!armed) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire = armed && tick && (cnt_q == LAST);
endmodule

// File: rtl/sim_class_sel.sv
module sim_class_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic batt_ok,
  input  logic idle_empty,
  input  logic timeout_evt,
  input  logic down_done,
  output logic sel_hi,
  output logic err
);
  logic fail_q, sel_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      sel_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (!batt_ok || idle_empty) begin
      fail_q <= 1'b0;
      sel_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (timeout_evt) fail_q <= 1'b1;
      if (down_done && fail_q) begin
        fail_q <= 1'b0;
        if (sel_q) begin
          err_q <= 1'b1;
          sel_q <= 1'b0;
        end else begin
          sel_q <= 1'b1;
        end
      end
    end
  end

  assign sel_hi = sel_q;
  assign err    = err_q;
endmodule

// File: rtl/sim_seq_fsm.sv
module sim_seq_fsm
  import sim_pwr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic batt_ok,
  input  logic card_in,
  input  logic tick,
  input  logic atr_stb,
  input  logic expire,
  input  logic err,
  output seq_t state,
  output logic timeout_evt,
  output logic down_done,
  output logic idle_empty
);
  seq_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_OFF:  if (tick && card_in && !err) st_d = ST_VCC;
      ST_VCC:  if (tick) st_d = ST_CLK;
      ST_CLK:  if (tick) st_d = ST_WAIT;
      ST_WAIT: begin
        if (tick && !card_in) st_d = ST_DRST;
        else if (atr_stb)     st_d = ST_RUN;
        else if (expire)      st_d = ST_DRST;
      end
      ST_RUN:  if (tick && !card_in) st_d = ST_DRST;
      ST_DRST: if (tick) st_d = ST_DCLK;
      ST_DCLK: if (tick) st_d = ST_OFF;
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= ST_OFF;
    else if (!batt_ok) st_q <= ST_OFF;
    else              st_q <= st_d;
  end

  assign state       = st_q;
  assign timeout_evt = (st_q == ST_WAIT) && card_in && !atr_stb && expire;
  assign down_done   = (st_q == ST_DCLK) && tick;
  assign idle_empty  = (st_q == ST_OFF) && !card_in;
endmodule

// File: rtl/sim_rate_div.sv
module sim_rate_div
  import sim_pwr_pkg::*;
#(
  parameter int unsigned DIV_0 = 372,
  parameter int unsigned DIV_1 = 64,
  parameter int unsigned DIV_2 = 32,
  parameter int unsigned DIV_3 = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate,
  input  logic       tick,
  input  logic [1:0] code,
  output logic       bit_tick
);
  localparam int unsigned DMAX = max4(DIV_0, DIV_1, DIV_2, DIV_3);
  localparam int unsigned CW   = $clog2(DMAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          wrap;
  logic          tick_q;

  assign last = CW'(pick_div(code, DIV_0, DIV_1, DIV_2, DIV_3) - 1);
  assign wrap = cnt_q >= last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= gate && tick && wrap;
      if (!gate)     cnt_q <= '0;
      else if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_tick = tick_q;
endmodule

// File: rtl/sim_pwr_ctrl.sv
module sim_pwr_ctrl
  import sim_pwr_pkg::*;
#(
  parameter int unsigned ATR_LIMIT = 40000,
  parameter int unsigned DIV_0     = 372,
  parameter int unsigned DIV_1     = 64,
  parameter int unsigned DIV_2     = 32,
  parameter int unsigned DIV_3     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       batt_present,
  input  logic       card_present,
  input  logic       atr_seen,
  input  logic       cclk_en,
  input  logic [1:0] rate_code,
  output logic       sup_en,
  output logic       sel_3v0,
  output logic       card_rst_n,
  output logic       cclk_gate,
  output logic       bit_tick,
  output logic       card_err
);
  seq_t  state;
  pins_t pins;
  logic  expire, timeout_evt, down_done, idle_empty, err, sel_hi;

  sim_atr_timer #(.ATR_LIMIT(ATR_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .armed(state == ST_WAIT),
    .tick(cclk_en), .expire(expire)
  );

  sim_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .batt_ok(batt_present), .card_in(card_present),
    .tick(cclk_en), .atr_stb(atr_seen), .expire(expire), .err(err),
    .state(state), .timeout_evt(timeout_evt), .down_done(down_done),
    .idle_empty(idle_empty)
  );

  sim_class_sel u_class (
    .clk(clk), .rst_n(rst_n), .batt_ok(batt_present), .idle_empty(idle_empty),
    .timeout_evt(timeout_evt), .down_done(down_done),
    .sel_hi(sel_hi), .err(err)
  );

  assign pins = pins_of(state);

  sim_rate_div #(.DIV_0(DIV_0), .DIV_1(DIV_1), .DIV_2(DIV_2), .DIV_3(DIV_3)) u_div (
    .clk(clk), .rst_n(rst_n), .gate(pins.clk), .tick(cclk_en),
    .code(rate_code), .bit_tick(bit_tick)
  );

  assign sup_en     = pins.vcc;
  assign cclk_gate  = pins.clk;
  assign card_rst_n = pins.rls;
  assign sel_3v0    = sel_hi;
  assign card_err   = err;
endmodule

// File: rtl/sim_pwr_chk.sv
module sim_pwr_chk (
  input logic clk,
  input logic rst_n,
  input logic batt_present,
  input logic sup_en,
  input logic sel_3v0,
  input logic card_rst_n,
  input logic cclk_gate,
  input logic bit_tick,
  input logic card_err,
  input logic timeout_evt
);
  p_supply_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_en |-> (!cclk_gate && !card_rst_n));

  p_clock_before_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_gate |-> !card_rst_n);

  p_timeout_resets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !card_rst_n);

  p_class_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sup_en |-> $stable(sel_3v0));

  p_err_unpowered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    card_err |-> !sup_en);

  p_batt_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_present |=> (!sup_en && !card_err && !sel_3v0));

  p_tick_needs_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> $past(cclk_gate));
endmodule

bind sim_pwr_ctrl sim_pwr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .batt_present(batt_present), .sup_en(sup_en),
  .sel_3v0(sel_3v0), .card_rst_n(card_rst_n), .cclk_gate(cclk_gate),
  .bit_tick(bit_tick), .card_err(card_err), .timeout_evt(timeout_evt)
);

// File: tb/sim_pwr_ctrl_tb.sv
module sim_pwr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic batt_present = 1'b0, card_present = 1'b0, atr_seen = 1'b0, cclk_en = 1'b0;
  logic [1:0] rate_code = 2'd3;
  logic sup_en, sel_3v0, card_rst_n, cclk_gate, bit_tick, card_err;

  int compared = 0, mismatched = 0, cyc = 0, tick_per = 1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sim_pwr_ctrl #(.ATR_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .batt_present(batt_present), .card_present(card_present),
    .atr_seen(atr_seen), .cclk_en(cclk_en), .rate_code(rate_code),
    .sup_en(sup_en), .sel_3v0(sel_3v0), .card_rst_n(card_rst_n),
    .cclk_gate(cclk_gate), .bit_tick(bit_tick), .card_err(card_err)
  );

  // Behavioural reference: phase 0 off, 1 supply, 2 clock, 3 awaiting answer,
  // 4 active, 5 reset dropped, 6 clock stopped.
  int ph = 0, wcnt = 0, dcnt = 0;
  bit m_v3 = 0, m_fail = 0, m_err = 0, m_bt = 0;
  int divs[4] = '{372, 64, 32, 16};

  function automatic bit ph_sup(int p);  return p != 0; endfunction
  function automatic bit ph_clk(int p);  return p == 2 || p == 3 || p == 4 || p == 5; endfunction
  function automatic bit ph_rls(int p);  return p == 3 || p == 4; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; wcnt = 0; dcnt = 0; m_v3 = 0; m_fail = 0; m_err = 0; m_bt = 0;
    end else begin
      int d;
      d = divs[rate_code];
      m_bt = ph_clk(ph) && cclk_en && (dcnt >= d - 1);
      if (!ph_clk(ph)) dcnt = 0;
      else if (cclk_en) dcnt = (dcnt >= d - 1) ? 0 : dcnt + 1;
      if (!batt_present) begin
        ph = 0; m_v3 = 0; m_fail = 0; m_err = 0;
      end else begin
        case (ph)
          0: if (!card_present) begin m_v3 = 0; m_err = 0; m_fail = 0; end
             else if (cclk_en && !m_err) ph = 1;
          1: if (cclk_en) ph = 2;
          2: if (cclk_en) begin ph = 3; wcnt = 0; end
          3: if (cclk_en && !card_present) ph = 5;
             else if (atr_seen) ph = 4;
             else if (cclk_en) begin
               if (wcnt == LIM - 1) begin ph = 5; m_fail = 1; end
               else wcnt++;
             end
          4: if (cclk_en && !card_present) ph = 5;
          5: if (cclk_en) ph = 6;
          6: if (cclk_en) begin
               ph = 0;
               if (m_fail) begin
                 m_fail = 0;
                 if (m_v3) begin m_err = 1; m_v3 = 0; end
                 else m_v3 = 1;
               end
             end
          default: ph = 0;
        endcase
      end
    end
  end

  task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, nm, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cmp("R2", "sup_en", sup_en, ph_sup(ph));
    cmp("R2", "cclk_gate", cclk_gate, ph_clk(ph));
    cmp("R4", "card_rst_n", card_rst_n, ph_rls(ph));
    cmp("R5", "sel_3v0", sel_3v0, m_v3);
    cmp("R6", "card_err", card_err, m_err);
    cmp("R9", "bit_tick", bit_tick, m_bt);
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      atr_seen = 1'b0;
      cclk_en = (tick_per != 0) && (cyc % tick_per == 0);
    end
  endtask

  task automatic finish_up;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    int t_s, t_c, t_r, gap, k, last;
    adv(3);
    rst_n = 1'b1;
    adv(2);
    // R1: reset state
    chk("R1 outputs idle", {sup_en, cclk_gate, card_rst_n, bit_tick, card_err, sel_3v0}, 0);

    // R2: activation order, one card clock apart, 1.8 V first
    batt_present = 1; card_present = 1; tick_per = 1;
    t_s = -1; t_c = -1; t_r = -1;
    for (int i = 0; i < 40 && t_r < 0; i++) begin
      adv(1);
      if (sup_en && t_s < 0) t_s = i;
      if (cclk_gate && t_c < 0) t_c = i;
      if (card_rst_n && t_r < 0) t_r = i;
    end
    chk("R2 clock after supply", t_c - t_s, 1);
    chk("R2 release after clock", t_r - t_c, 1);
    chk("R2 first class 1.8V", sel_3v0, 0);

    // R3: answer keeps the card up
    atr_seen = 1; adv(1);
    adv(3 * LIM);
    chk("R3 still released", card_rst_n, 1);

    // R9: bit periods for each code
    for (int c = 3; c >= 0; c--) begin
      rate_code = 2'(c);
      k = 0; last = -1; gap = 0;
      for (int i = 0; i < 1200 && k < 3; i++) begin
        adv(1);
        if (bit_tick) begin
          if (last >= 0) gap = i - last;
          last = i; k++;
        end
      end
      chk($sformatf("R9 period code %0d", c), gap, divs[c]);
    end

    // R8: removal gives ordered teardown, no error
    card_present = 0;
    t_r = -1; t_c = -1; t_s = -1;
    for (int i = 0; i < 20 && t_s < 0; i++) begin
      adv(1);
      if (!card_rst_n && t_r < 0) t_r = i;
      if (!cclk_gate && t_c < 0) t_c = i;
      if (!sup_en && t_s < 0) t_s = i;
    end
    chk("R8 clock stops after reset", t_c - t_r, 1);
    chk("R8 supply off after clock", t_s - t_c, 1);
    chk("R8 no error", card_err, 0);

    // R4/R5/R10: no answer, sparse enables, fall back to 3 V
    adv(4);
    tick_per = 2; card_present = 1;
    k = 0;
    for (int i = 0; i < 400 && !(sup_en && sel_3v0 && card_rst_n); i++) adv(1);
    chk("R5 retry at 3V", sel_3v0, 1);
    gap = 0;
    while (card_rst_n && gap < 400) begin adv(1); gap++; end
    chk("R4 R10 timeout window cycles", gap, 2 * LIM);
    for (int i = 0; i < 100 && !card_err; i++) adv(1);
    chk("R6 error latched", card_err, 1);
    adv(100);
    chk("R6 stays unpowered", sup_en, 0);
    chk("R6 class back to 1.8V", sel_3v0, 0);

    card_present = 0; adv(4);
    chk("R6 removal clears error", card_err, 0);

    // R10: no enables, no activation
    tick_per = 0; card_present = 1; adv(50);
    chk("R10 no step without enable", sup_en, 0);

    // R7: battery loss mid-session
    tick_per = 1;
    for (int i = 0; i < 20 && !card_rst_n; i++) adv(1);
    atr_seen = 1; adv(1);
    adv(5);
    batt_present = 0; adv(1);
    chk("R7 immediate power-down", {sup_en, cclk_gate, card_rst_n}, 0);
    adv(3);
    batt_present = 1;
    for (int i = 0; i < 20 && !card_rst_n; i++) adv(1);
    chk("R7 restart at 1.8V", sel_3v0, 0);
    adv(5);
    finish_up();
  end
endmodule